// File: doc/BRIEF.md
# Instruction Fetch Cache with Bypass Router

This block sits in front of a secondary processor's 32-bit request port. It splits the traffic by access type. Cacheable instruction fetches are looked up in a small direct-mapped cache of 256-bit lines. A miss is refilled over a 64-bit read port in four beats, starting with the beat that holds the requested word. Every other access is forwarded unchanged to a separate 32-bit downstream port. That traffic covers data reads, writes, non-cacheable fetches and accesses from non-processor masters sharing the port.

A 256-bit line buffer collects the refill beats. The stalled fetch is released as soon as its own word arrives. The rest of the line then completes in the background, and during that time hits and bypass traffic continue. A configurable top-address window, the configuration space, can be reached through neither path, and accesses to it end at once with an error. A flush input drops every cached line. A write that lands on a cached line drops that line, so code modified through the data path is fetched again.

The upstream handshake is simple. The requester raises `up_req` with its address and attributes and holds them until `up_ready` is high at a clock edge. The refill port is a two-phase request. `fill_req` and `fill_addr` are held until `fill_gnt`. After that, four `fill_valid` beats follow, with gaps of any length between them.

Top module: `ifetch_cache`

## Requirements
- R1: After reset every line is invalid. With `up_req` low, the outputs `up_ready`, `fill_req` and `byp_req` are all low. The first cacheable fetch to any address misses.
- R2: A cacheable fetch (`up_write`=0, `up_instr`=1, `up_cacheable`=1) that misses raises `fill_req`. `fill_addr` is the fetch address with bits [2:0] cleared. Both are held stable until `fill_gnt` is seen.
- R3: A refill consists of exactly four `fill_valid` beats. Beat k carries line chunk (a[4:3]+k) mod 4, where a is `fill_addr`. Each beat holds chunk bytes 0-3 in bits [31:0] and bytes 4-7 in bits [63:32]. The stalled fetch completes in the cycle of beat 0, with the upper half of the beat if address bit 2 is 1 and the lower half otherwise.
- R4: Once a line is installed, a cacheable fetch to any of its eight words completes in the same cycle it is presented. It returns the word from the refill and raises no `fill_req`.
- R5: The cache is direct-mapped. The line index is address bits [10:5] and the tag is bits [31:11]. A fetch with the same index and a different tag misses and replaces the line held there.
- R6: Every request other than a cacheable fetch is routed to the bypass port. This covers data reads, non-cacheable fetches and writes. Address, write flag and write data pass unchanged. `up_ready`, `up_rdata` and `up_err` follow `byp_ready`, `byp_rdata` and `byp_err`.
- R7: Any request whose address bits [31:20] equal `CFG_TAG` (default 0x5A0) completes in the same cycle with `up_err`=1. It raises neither `byp_req` nor `fill_req`.
- R8: Writes never install a line. A bypassed write that completes to an address in a cached line, or in the line being refilled, leaves that line invalid, so the next fetch to it misses.
- R9: A one-cycle `flush_all` pulse invalidates all 64 lines. A refill in progress at that time completes on the port but is not installed.
- R10: After the critical word is delivered, hits and bypass accesses are served while the remaining beats arrive. A fetch that misses during that time stalls until the refill is done, and then starts its own refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream request valid, held until `up_ready` |
| up_addr | input | 32 | Upstream byte address |
| up_write | input | 1 | 1 for a write |
| up_instr | input | 1 | 1 for an instruction fetch |
| up_cacheable | input | 1 | 1 if the access may be cached |
| up_wdata | input | 32 | Write data |
| up_ready | output | 1 | Request completes at this edge |
| up_rdata | output | 32 | Read data, valid with `up_ready` |
| up_err | output | 1 | Error response, valid with `up_ready` |
| flush_all | input | 1 | Invalidate every line, abort refill install |
| fill_req | output | 1 | Refill request, held until `fill_gnt` |
| fill_addr | output | 32 | 8-byte aligned address of the critical beat |
| fill_gnt | input | 1 | Refill request accepted |
| fill_valid | input | 1 | Refill beat valid |
| fill_data | input | 64 | Refill beat data |
| byp_req | output | 1 | Bypass request valid |
| byp_addr | output | 32 | Bypass address |
| byp_write | output | 1 | Bypass write flag |
| byp_wdata | output | 32 | Bypass write data |
| byp_ready | input | 1 | Bypass access completes |
| byp_rdata | input | 32 | Bypass read data |
| byp_err | input | 1 | Bypass error response |

## Verification
Several properties are checked on every cycle. A hit is always answered in the cycle it is presented. Refill and bypass requests are never raised together. A configuration-space access never leaks to the bypass port. The refill request holds while it waits for its grant. The critical word is released only once per refill. A flush or a write probe leaves the affected valid bits clear. Other behaviour can only be shown by the bench's scenarios. That includes whether beat data lands in the right chunk under the wrapping order, and whether an aborted refill really causes a fresh miss later. It also includes whether traffic keeps moving during a background refill, and whether the returned words match memory across mixed random traffic.

// File: rtl/ifc_pkg.sv
// Shared constants and types for the instruction fetch cache.
// Assumes a 32-bit word, 64-bit refill beat and 256-bit line.
package ifc_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BEAT_W     = 64;
    localparam int unsigned LINE_W     = 256;
    localparam int unsigned BEATS      = LINE_W / BEAT_W;
    localparam int unsigned BEAT_IDX_W = $clog2(BEATS);
    localparam int unsigned OFF_W      = $clog2(LINE_W / 8);
    localparam int unsigned BEAT_OFF   = $clog2(BEAT_W / 8);
    localparam int unsigned WSEL_W     = OFF_W - 2;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_CRIT = 2'd2,
        FS_BG   = 2'd3
    } fill_state_t;
endpackage

// File: rtl/ifc_tag_array.sv
// Valid bits and tags of a direct-mapped cache.
// Looks up one line identifier combinationally. Supports a full flush,
// a single-line probe invalidate and a line install. Priority:
// flush over install over probe invalidate.
module ifc_tag_array
    import ifc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-OFF_W-1:0]   look_line,
    output logic                      look_hit,
    input  logic                      flush,
    input  logic                      probe_inv,
    input  logic                      inst_en,
    input  logic [ADDR_W-OFF_W-1:0]   inst_line
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    logic [IDX_W-1:0] look_idx, inst_idx;
    logic [TAG_W-1:0] look_tag, inst_tag;

    assign look_idx = look_line[IDX_W-1:0];
    assign look_tag = look_line[ADDR_W-OFF_W-1:IDX_W];
    assign inst_idx = inst_line[IDX_W-1:0];
    assign inst_tag = inst_line[ADDR_W-OFF_W-1:IDX_W];

    // Lookup: valid line with matching tag
    assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

    // Valid bit update with flush, install and probe invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (probe_inv && look_hit) valid_q[look_idx] <= 1'b0;
            if (inst_en) valid_q[inst_idx] <= 1'b1;
        end
    end

    // Tag write on install
    always_ff @(posedge clk) begin
        if (inst_en) tag_q[inst_idx] <= inst_tag;
    end

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    p_probe_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_inv && look_hit && !flush && !(inst_en && inst_idx == look_idx))
        |=> !valid_q[$past(look_idx)]);
endmodule

// File: rtl/ifc_line_store.sv
// Line data storage. Writes a whole line, reads one word combinationally.
// Assumes one write port and one read port, no reset of contents.
module ifc_line_store
    import ifc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_sel,
    output logic [WORD_W-1:0] rd_word
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] mem_q [LINES];

    // Whole-line write on install
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_line;
    end

    // Word select from the addressed line
    assign rd_word = mem_q[rd_idx][int'(rd_sel)*WORD_W +: WORD_W];
endmodule

// File: rtl/ifc_fill_seq.sv
// Refill sequencer with line buffer. Issues one refill request, collects
// BEATS wrapped beats starting at the critical one, releases the critical
// word and installs the line after the last beat unless aborted.
// Assumes the requester holds its request until the critical word is out.
module ifc_fill_seq
    import ifc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:2]       start_addr,
    input  logic                    abort,
    input  logic                    fill_gnt,
    input  logic                    fill_valid,
    input  logic [BEAT_W-1:0]       fill_data,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    output logic                    crit_valid,
    output logic [WORD_W-1:0]       crit_word,
    output logic                    busy,
    output logic [ADDR_W-OFF_W-1:0] line_id,
    output logic                    inst_en,
    output logic [LINE_W-1:0]       inst_line
);
    fill_state_t           state_q;
    logic [ADDR_W-1:2]     addr_q;
    logic [BEAT_IDX_W-1:0] cnt_q;
    logic [BEAT_IDX_W-1:0] chunk;
    logic [LINE_W-1:0]     buf_q;
    logic                  dead_q;
    logic                  beat_take;
    logic                  last_beat;

    assign chunk     = addr_q[OFF_W-1:BEAT_OFF] + cnt_q;
    assign beat_take = fill_valid && (state_q == FS_CRIT || state_q == FS_BG);
    assign last_beat = (cnt_q == BEAT_IDX_W'(BEATS - 1));

    assign fill_req   = (state_q == FS_REQ);
    assign fill_addr  = {addr_q[ADDR_W-1:BEAT_OFF], BEAT_OFF'(0)};
    assign crit_valid = fill_valid && (state_q == FS_CRIT);
    assign crit_word  = fill_data[int'(addr_q[BEAT_OFF-1:2])*WORD_W +: WORD_W];
    assign busy       = (state_q != FS_IDLE);
    assign line_id    = addr_q[ADDR_W-1:OFF_W];
    assign inst_en    = beat_take && last_beat && !dead_q && !abort;

    // Line buffer with the arriving beat merged into its chunk slot
    always_comb begin
        inst_line = buf_q;
        inst_line[int'(chunk)*BEAT_W +: BEAT_W] = fill_data;
    end

    // Refill state machine, beat counter and abort flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            dead_q  <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: if (start) begin
                    state_q <= FS_REQ;
                    addr_q  <= start_addr;
                    cnt_q   <= '0;
                    dead_q  <= 1'b0;
                end
                FS_REQ: if (fill_gnt) state_q <= FS_CRIT;
                default: if (fill_valid) begin
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= last_beat ? FS_IDLE : FS_BG;
                end
            endcase
            if (abort && state_q != FS_IDLE) dead_q <= 1'b1;
        end
    end

    // Beat capture into the line buffer
    always_ff @(posedge clk) begin
        if (beat_take) buf_q <= inst_line;
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_gnt) |=> (fill_req && $stable(fill_addr)));

    p_crit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid |=> !crit_valid);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_take && last_beat) |=> !busy);
endmodule

// File: rtl/ifetch_cache.sv
// Instruction fetch cache with bypass router. Cacheable fetches are served
// from a direct-mapped line cache refilled over a wide port; all other
// accesses pass to a narrow bypass port; a configuration window is refused.
// Assumes upstream holds request fields stable until up_ready.
module ifetch_cache
    import ifc_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter int                 IDX_W     = 6,
    parameter int                 CFG_TAG_W = 12,
    parameter logic [CFG_TAG_W-1:0] CFG_TAG = 12'h5A0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic              up_instr,
    input  logic              up_cacheable,
    input  logic [WORD_W-1:0] up_wdata,
    output logic              up_ready,
    output logic [WORD_W-1:0] up_rdata,
    output logic              up_err,
    input  logic              flush_all,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_gnt,
    input  logic              fill_valid,
    input  logic [BEAT_W-1:0] fill_data,
    output logic              byp_req,
    output logic [ADDR_W-1:0] byp_addr,
    output logic              byp_write,
    output logic [WORD_W-1:0] byp_wdata,
    input  logic              byp_ready,
    input  logic [WORD_W-1:0] byp_rdata,
    input  logic              byp_err
);
    localparam int LINE_ID_W = ADDR_W - OFF_W;

    logic                 cfg_hit, fetch_sel, byp_sel, hit;
    logic                 fill_start, fill_busy, fill_match, wr_probe, abort;
    logic                 crit_valid, inst_en;
    logic [WORD_W-1:0]    crit_word, rd_word;
    logic [LINE_ID_W-1:0] up_line, fill_line;
    logic [LINE_W-1:0]    inst_line;

    assign up_line    = up_addr[ADDR_W-1:OFF_W];
    assign cfg_hit    = (up_addr[ADDR_W-1 -: CFG_TAG_W] == CFG_TAG);
    assign fetch_sel  = up_req && !cfg_hit && !up_write && up_instr && up_cacheable;
    assign byp_sel    = up_req && !cfg_hit && !fetch_sel;
    assign fill_start = fetch_sel && !hit && !fill_busy;
    assign fill_match = fill_busy && (up_line == fill_line);
    assign wr_probe   = byp_sel && up_write && byp_ready;
    assign abort      = flush_all || (wr_probe && fill_match);

    assign byp_req   = byp_sel;
    assign byp_addr  = up_addr;
    assign byp_write = up_write;
    assign byp_wdata = up_wdata;

    ifc_tag_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (up_line),
        .look_hit  (hit),
        .flush     (flush_all),
        .probe_inv (wr_probe),
        .inst_en   (inst_en),
        .inst_line (fill_line)
    );

    ifc_line_store #(.IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .wr_en   (inst_en),
        .wr_idx  (fill_line[IDX_W-1:0]),
        .wr_line (inst_line),
        .rd_idx  (up_line[IDX_W-1:0]),
        .rd_sel  (up_addr[OFF_W-1:2]),
        .rd_word (rd_word)
    );

    ifc_fill_seq #(.ADDR_W(ADDR_W)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .start_addr (up_addr[ADDR_W-1:2]),
        .abort      (abort),
        .fill_gnt   (fill_gnt),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .fill_req   (fill_req),
        .fill_addr  (fill_addr),
        .crit_valid (crit_valid),
        .crit_word  (crit_word),
        .busy       (fill_busy),
        .line_id    (fill_line),
        .inst_en    (inst_en),
        .inst_line  (inst_line)
    );

    // Upstream response selection by path
    always_comb begin
        up_ready = 1'b0;
        up_rdata = '0;
        up_err   = 1'b0;
        if (up_req && cfg_hit) begin
            up_ready = 1'b1;
            up_err   = 1'b1;
        end else if (fetch_sel) begin
            if (hit) begin
                up_ready = 1'b1;
                up_rdata = rd_word;
            end else if (crit_valid) begin
                up_ready = 1'b1;
                up_rdata = crit_word;
            end
        end else if (byp_sel) begin
            up_ready = byp_ready;
            up_rdata = byp_rdata;
            up_err   = byp_err;
        end
    end

    p_hit_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_sel && hit) |-> (up_ready && !up_err && !fill_req));

    p_path_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(byp_req && fill_req));

    p_cfg_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && cfg_hit) |-> (up_ready && up_err && !byp_req));

    p_miss_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_sel && !hit && !crit_valid) |-> !up_ready);
endmodule

// File: tb/sim_ifetch_cache.sv
module sim_ifetch_cache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_req, up_write, up_instr, up_cacheable;
    logic [31:0] up_addr, up_wdata;
    logic        up_ready, up_err;
    logic [31:0] up_rdata;
    logic        flush_all;
    logic        fill_req, fill_gnt, fill_valid;
    logic [31:0] fill_addr;
    logic [63:0] fill_data;
    logic        byp_req, byp_write, byp_ready, byp_err;
    logic [31:0] byp_addr, byp_wdata, byp_rdata;

    int n_chk = 0, n_fail = 0;
    int n_fills = 0, n_byp = 0;
    bit fill_active = 0;
    logic [31:0] last_fill_addr, last_byp_addr, last_byp_wdata;
    bit last_byp_write;
    bit rand_mode = 0;
    int gnt_delay = 0, beat_gap = 0, byp_delay = 0;
    bit byp_err_next = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .up_req(up_req), .up_addr(up_addr), .up_write(up_write), .up_instr(up_instr),
        .up_cacheable(up_cacheable), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
        .flush_all(flush_all),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_gnt(fill_gnt),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .byp_req(byp_req), .byp_addr(byp_addr), .byp_write(byp_write), .byp_wdata(byp_wdata),
        .byp_ready(byp_ready), .byp_rdata(byp_rdata), .byp_err(byp_err)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] byp_word(input logic [31:0] a);
        return ~mem_word(a) ^ 32'h00FF_00FF;
    endfunction

    // Beat k of a refill: chunk (crit + k) mod 4, low word at lower address
    function automatic logic [63:0] beat_data(input logic [31:0] fa, input int k);
        logic [31:0] base;
        logic [1:0]  c;
        base = {fa[31:5], 5'b0};
        c = fa[4:3] + 2'(k);
        return {mem_word(base + {27'd0, c, 3'd4}), mem_word(base + {27'd0, c, 3'd0})};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Refill memory model
    initial begin
        fill_gnt = 0; fill_valid = 0; fill_data = '0;
        forever begin : fill_loop
            logic [31:0] fa;
            int gd;
            @(negedge clk);
            if (rst_n && fill_req) begin
                fa = fill_addr;
                n_fills++;
                last_fill_addr = fa;
                fill_active = 1;
                gd = rand_mode ? int'($urandom_range(0, 2)) : gnt_delay;
                repeat (gd) @(negedge clk);
                fill_gnt = 1;
                @(negedge clk);
                fill_gnt = 0;
                for (int k = 0; k < 4; k++) begin
                    int bg;
                    bg = rand_mode ? int'($urandom_range(0, 2)) : beat_gap;
                    repeat (bg) @(negedge clk);
                    fill_valid = 1;
                    fill_data  = beat_data(fa, k);
                    @(negedge clk);
                    fill_valid = 0;
                end
                fill_active = 0;
            end
        end
    end

    // Bypass target model
    initial begin
        byp_ready = 0; byp_rdata = '0; byp_err = 0;
        forever begin : byp_loop
            int d;
            @(negedge clk);
            if (rst_n && byp_req) begin
                d = rand_mode ? int'($urandom_range(0, 2)) : byp_delay;
                n_byp++;
                last_byp_addr  = byp_addr;
                last_byp_write = byp_write;
                last_byp_wdata = byp_wdata;
                repeat (d) @(negedge clk);
                byp_ready = 1;
                byp_rdata = byp_word(last_byp_addr);
                byp_err   = byp_err_next;
                @(negedge clk);
                byp_ready = 0;
                byp_err   = 0;
            end
        end
    end

    task automatic access(input logic [31:0] a, input bit wr, input bit ins, input bit cach,
                          input logic [31:0] wd, output logic [31:0] rd, output bit er,
                          output int lat);
        @(negedge clk);
        up_req = 1; up_addr = a; up_write = wr; up_instr = ins;
        up_cacheable = cach; up_wdata = wd;
        lat = 0;
        #1;
        while (!up_ready && lat < 400) begin
            @(negedge clk);
            #1;
            lat++;
        end
        if (!up_ready) chk(0, "R10", "access timeout", a, 32'h0);
        rd = up_rdata;
        er = up_err;
        @(negedge clk);
        up_req = 0; up_write = 0;
    endtask

    task automatic fetch_chk(input logic [31:0] a, input string req, output int lat);
        logic [31:0] rd;
        bit er;
        access(a, 0, 1, 1, 32'h0, rd, er, lat);
        chk(rd == mem_word(a) && !er, req, "fetch data", rd, mem_word(a));
    endtask

    task automatic wait_fill_idle();
        while (fill_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] A = 32'h0800_0014;
    localparam logic [31:0] B = A + 32'h800;
    localparam logic [31:0] D = 32'h0800_0400;
    localparam logic [31:0] E = 32'h0800_0600;
    localparam logic [31:0] F = 32'h0800_0640;
    localparam logic [31:0] G = 32'h0800_0680;
    localparam logic [31:0] H = 32'h0800_06C8;
    localparam logic [31:0] CFG = 32'h5A00_0010;

    initial begin : main
        int lat, f0, b0;
        logic [31:0] rd;
        bit er;
        rst_n = 0; up_req = 0; up_addr = '0; up_write = 0; up_instr = 0;
        up_cacheable = 0; up_wdata = '0; flush_all = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!up_ready && !fill_req && !byp_req, "R1", "idle outputs after reset",
            {29'd0, up_ready, fill_req, byp_req}, 32'h0);

        // R1/R2/R3 first fetch misses, critical word first
        gnt_delay = 3; beat_gap = 1;
        f0 = n_fills;
        fetch_chk(A, "R3", lat);
        chk(n_fills == f0 + 1, "R1", "first fetch misses", n_fills, f0 + 1);
        chk(last_fill_addr == 32'h0800_0010, "R2", "fill address aligned", last_fill_addr, 32'h0800_0010);
        chk(lat > 0, "R3", "miss stalls", lat, 1);
        wait_fill_idle();
        gnt_delay = 0; beat_gap = 0;

        // R4/R3 every word of the line hits with wrapped beat order honoured
        for (int w = 0; w < 8; w++) begin
            fetch_chk({A[31:5], 5'b0} + 32'(w * 4), "R3", lat);
            chk(lat == 0, "R4", "hit same cycle", lat, 0);
        end
        chk(n_fills == f0 + 1, "R4", "hits issue no refill", n_fills, f0 + 1);

        // R5 same index, different tag replaces
        fetch_chk(B, "R5", lat); wait_fill_idle();
        chk(n_fills == f0 + 2, "R5", "conflict miss", n_fills, f0 + 2);
        fetch_chk(A, "R5", lat); wait_fill_idle();
        chk(n_fills == f0 + 3, "R5", "evicted line misses", n_fills, f0 + 3);
        fetch_chk(A, "R5", lat);
        chk(lat == 0, "R5", "reloaded line hits", lat, 0);

        // R6 data read, non-cacheable fetch, error passthrough go to bypass
        f0 = n_fills; b0 = n_byp;
        access(A, 0, 0, 1, 32'h0, rd, er, lat);
        chk(rd == byp_word(A) && !er, "R6", "data read via bypass", rd, byp_word(A));
        chk(last_byp_addr == A && !last_byp_write, "R6", "bypass addr", last_byp_addr, A);
        access(A, 0, 1, 0, 32'h0, rd, er, lat);
        chk(rd == byp_word(A), "R6", "noncacheable fetch via bypass", rd, byp_word(A));
        byp_err_next = 1;
        access(A + 8, 0, 0, 0, 32'h0, rd, er, lat);
        byp_err_next = 0;
        chk(er, "R6", "bypass error passed", {31'd0, er}, 32'h1);
        chk(n_byp == b0 + 3 && n_fills == f0, "R6", "bypass count", n_byp, b0 + 3);

        // R8 write to cached line: passes through, then line misses
        access(A + 4, 1, 0, 1, 32'hCAFE_F00D, rd, er, lat);
        chk(last_byp_write && last_byp_wdata == 32'hCAFE_F00D, "R6", "write data passed",
            last_byp_wdata, 32'hCAFE_F00D);
        fetch_chk(A, "R8", lat); wait_fill_idle();
        chk(n_fills == f0 + 1, "R8", "write-hit line refetched", n_fills, f0 + 1);
        access(D, 1, 0, 1, 32'h1234_0000, rd, er, lat);
        fetch_chk(D, "R8", lat); wait_fill_idle();
        chk(n_fills == f0 + 2, "R8", "write did not allocate", n_fills, f0 + 2);

        // R7 configuration window refused
        b0 = n_byp; f0 = n_fills;
        access(CFG, 0, 0, 0, 32'h0, rd, er, lat);
        chk(er && lat == 0, "R7", "cfg read error", {31'd0, er}, 32'h1);
        access(CFG, 0, 1, 1, 32'h0, rd, er, lat);
        chk(er && lat == 0, "R7", "cfg fetch error", {31'd0, er}, 32'h1);
        access(CFG, 1, 0, 0, 32'h77, rd, er, lat);
        chk(er, "R7", "cfg write error", {31'd0, er}, 32'h1);
        chk(n_byp == b0 && n_fills == f0, "R7", "cfg reached no port", n_byp + n_fills, b0 + f0);

        // R9 flush drops cached line
        fetch_chk(A, "R9", lat);
        chk(lat == 0, "R9", "line cached before flush", lat, 0);
        pulse_flush();
        f0 = n_fills;
        fetch_chk(A, "R9", lat); wait_fill_idle();
        chk(n_fills == f0 + 1, "R9", "flushed line misses", n_fills, f0 + 1);

        // R9 flush during background fill: not installed
        beat_gap = 6;
        fetch_chk(E, "R9", lat);
        chk(fill_active, "R9", "fill still running", {31'd0, fill_active}, 32'h1);
        pulse_flush();
        wait_fill_idle();
        beat_gap = 0;
        f0 = n_fills;
        fetch_chk(E, "R9", lat); wait_fill_idle();
        chk(n_fills == f0 + 1, "R9", "aborted fill refetched", n_fills, f0 + 1);

        // R8 write into line being filled aborts install
        beat_gap = 6;
        fetch_chk(F, "R8", lat);
        access(F + 8, 1, 0, 1, 32'h55, rd, er, lat);
        chk(fill_active, "R8", "write during fill", {31'd0, fill_active}, 32'h1);
        wait_fill_idle();
        beat_gap = 0;
        f0 = n_fills;
        fetch_chk(F, "R8", lat); wait_fill_idle();
        chk(n_fills == f0 + 1, "R8", "written fill line refetched", n_fills, f0 + 1);

        // R10 traffic continues during background fill
        fetch_chk(A, "R10", lat);
        beat_gap = 8;
        f0 = n_fills;
        fetch_chk(G, "R10", lat);
        fetch_chk(A, "R10", lat);
        chk(lat == 0 && fill_active, "R10", "hit under fill", lat, 0);
        access(D, 0, 0, 1, 32'h0, rd, er, lat);
        chk(rd == byp_word(D) && fill_active, "R10", "bypass under fill", rd, byp_word(D));
        fetch_chk(H, "R10", lat);
        chk(n_fills == f0 + 2, "R10", "miss waits then refills", n_fills, f0 + 2);
        wait_fill_idle();
        beat_gap = 0;
        fetch_chk(G, "R10", lat);
        chk(lat == 0, "R10", "earlier fill installed", lat, 0);
        fetch_chk(H, "R10", lat);
        chk(lat == 0, "R10", "later fill installed", lat, 0);

        // Random mixed traffic
        rand_mode = 1;
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] a;
            op = int'($urandom_range(0, 99));
            a = 32'h0800_0000 + ($urandom_range(0, 3) << 11) + ($urandom_range(0, 7) << 5)
                + ($urandom_range(0, 7) << 2);
            if (op < 68) begin
                fetch_chk(a, "R4", lat);
            end else if (op < 78) begin
                access(a, 0, 0, 1, 32'h0, rd, er, lat);
                chk(rd == byp_word(a) && !er, "R6", "random data read", rd, byp_word(a));
            end else if (op < 86) begin
                access(a, 0, 1, 0, 32'h0, rd, er, lat);
                chk(rd == byp_word(a) && !er, "R6", "random noncache fetch", rd, byp_word(a));
            end else if (op < 93) begin
                access(a, 1, 0, 1, $urandom, rd, er, lat);
                chk(!er, "R8", "random write", {31'd0, er}, 32'h0);
            end else if (op < 98) begin
                access(CFG + (a & 32'hFFFF), op[0], 1, 1, 32'h0, rd, er, lat);
                chk(er, "R7", "random cfg access", {31'd0, er}, 32'h1);
            end else begin
                pulse_flush();
            end
        end
        rand_mode = 0;
        wait_fill_idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule